// File: doc/BRIEF.md
# Multiplexed CPU Bus Demultiplexer

This block connects a processor with a time-shared low address/data byte and a shared upper address/status nibble to a plain system bus. Early in each bus cycle, while the address-latch strobe is high, the block captures the address information that appears on the shared pins. It holds that information after the pins switch over to carrying data or status. As a result, the system side sees a steady 20-bit address for the whole cycle. The middle address byte is split into two parts. Its lower nibble goes through the same latch as the other shared lines. Its upper nibble passes straight through, because the processor keeps it valid for the whole cycle.

The 8-bit data path is not a real tristate pin. It is modelled as two one-way paths, each with its own output enable: one drives toward the processor and one drives toward the system bus. A path opens only in the data phase, which means the data-enable strobe is high and the address-latch strobe is low. The active-low read strobe picks which path opens. An interrupt-acknowledge cycle is handled as a special case: it always opens the path toward the processor so the vector byte can be read, and it never lets processor write data onto the bus. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `cpu_bus_demux`

## Requirements
- R1: On a rising clock edge with `ale_i` high, `addr_o[7:0]` loads `cpu_ad_i`, `addr_o[11:8]` loads `cpu_amid_i[3:0]`, and `addr_o[19:16]` loads `cpu_ahi_i`.
- R2: On clock edges with `ale_i` low, `addr_o[19:16]`, `addr_o[11:8]` and `addr_o[7:0]` keep their values, even when the pins change.
- R3: `addr_o[15:12]` follows `cpu_amid_i[7:4]` combinationally, in the same cycle and without latching.
- R4: With `ale_i` low, `den_i` high, `inta_i` low and `rd_n_i` low, the outputs are `cpu_oe_o`=1, `bus_oe_o`=0 and `dir_to_cpu_o`=1, and `cpu_d_o` equals `sys_d_i`.
- R5: With `ale_i` low, `den_i` high, `inta_i` low and `rd_n_i` high, the outputs are `bus_oe_o`=1, `cpu_oe_o`=0 and `dir_to_cpu_o`=0, and `sys_d_o` equals `cpu_ad_i`.
- R6: With `den_i` low and `inta_i` low, both enables are 0 and both data outputs are 0. `dir_to_cpu_o` equals the inverse of `rd_n_i`.
- R7: While `ale_i` is high, both enables are 0, whatever the values of `den_i`, `rd_n_i` and `inta_i`.
- R8: With `inta_i` high and `ale_i` low, the outputs are `cpu_oe_o`=1, `bus_oe_o`=0 and `dir_to_cpu_o`=1, whatever the values of `den_i` and `rd_n_i`.
- R9: `cpu_oe_o` and `bus_oe_o` are never 1 at the same time.
- R10: While `rst_n` is low, the latched address bits are 0 and both enables are 0. The block leaves reset on the second rising clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ad_i | input | 8 | Shared low address/data byte from the processor |
| cpu_amid_i | input | 8 | Middle address byte (A15..A8) |
| cpu_ahi_i | input | 4 | Shared upper address/status nibble |
| ale_i | input | 1 | Address-latch strobe, active high |
| rd_n_i | input | 1 | Read strobe, active low |
| den_i | input | 1 | Data-phase enable strobe, active high |
| inta_i | input | 1 | Interrupt-acknowledge cycle indication, active high |
| sys_d_i | input | 8 | Data from the system bus |
| addr_o | output | 20 | Demultiplexed address |
| cpu_oe_o | output | 1 | Enable for driving data toward the processor |
| bus_oe_o | output | 1 | Enable for driving data onto the system bus |
| dir_to_cpu_o | output | 1 | Transfer direction, 1 = toward the processor |
| cpu_d_o | output | 8 | Data toward the processor, zero when disabled |
| sys_d_o | output | 8 | Data toward the system bus, zero when disabled |

## Verification
The hardest case to create from the ports is the hold: the address must survive after the shared pins have switched to data and status values. The stimulus first captures one address pattern with `ale_i` high. It then lowers the strobe and drives completely different values on every shared line. The address is read back over several following edges. The bench also changes the middle byte at that point, so the pass-through nibble moves while the latched nibble next to it does not. The interrupt-acknowledge override is reached by raising `inta_i` with `den_i` low and `rd_n_i` high, a combination in which a normal cycle would have both paths closed or would write.

// File: rtl/bdmx_pkg.sv
package bdmx_pkg;
  localparam int unsigned LO_W    = 8;
  localparam int unsigned MID_W   = 8;
  localparam int unsigned MLAT_W  = MID_W / 2;
  localparam int unsigned MPASS_W = MID_W - MLAT_W;
  localparam int unsigned HI_W    = 4;
  localparam int unsigned ADDR_W  = LO_W + MID_W + HI_W;
  localparam int unsigned RST_STAGES = 2;

  typedef struct packed {
    logic to_cpu;
    logic to_bus;
    logic dir_cpu;
  } steer_t;
endpackage

// File: rtl/bdmx_rst_sync.sv
module bdmx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/bdmx_addr_latch.sv
module bdmx_addr_latch #(
  parameter int unsigned LO_W   = 8,
  parameter int unsigned MLAT_W = 4,
  parameter int unsigned HI_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [LO_W-1:0]   lo_pin,
  input  logic [MLAT_W-1:0] mid_pin,
  input  logic [HI_W-1:0]   hi_pin,
  output logic [LO_W-1:0]   lo_q,
  output logic [MLAT_W-1:0] mid_q,
  output logic [HI_W-1:0]   hi_q
);
  localparam int unsigned HOLD_W = LO_W + MLAT_W + HI_W;

  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_d;
  logic              load_en;

  assign load_en = ale;

  always_comb begin
    hold_d = hold_q;
    if (load_en) hold_d = {hi_pin, mid_pin, lo_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign {hi_q, mid_q, lo_q} = hold_q;

  // R1
  capture_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (lo_q == $past(lo_pin)) && (hi_q == $past(hi_pin)) && (mid_q == $past(mid_pin)));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(hold_q));
endmodule

// File: rtl/bdmx_data_steer.sv
module bdmx_data_steer
  import bdmx_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter bit          ACK_NEEDS_DEN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_ok,
  input  logic          ale,
  input  logic          den,
  input  logic          rd_n,
  input  logic          inta,
  input  logic [DW-1:0] cpu_ad,
  input  logic [DW-1:0] sys_d,
  output steer_t        steer,
  output logic [DW-1:0] cpu_d,
  output logic [DW-1:0] bus_d
);
  logic data_phase;
  logic ack_phase;
  logic toward_cpu;

  generate
    if (ACK_NEEDS_DEN) begin : g_ack_gated
      assign ack_phase = inta && den && !ale;
    end else begin : g_ack_free
      assign ack_phase = inta && !ale;
    end
  endgenerate

  assign data_phase = den && !ale && !inta;
  assign toward_cpu = !rd_n || inta;

  always_comb begin
    steer.dir_cpu = toward_cpu;
    steer.to_cpu  = rst_ok && (ack_phase || (data_phase && !rd_n));
    steer.to_bus  = rst_ok && data_phase && rd_n;
    cpu_d = steer.to_cpu ? sys_d  : '0;
    bus_d = steer.to_bus ? cpu_ad : '0;
  end

  // R9
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(steer.to_cpu && steer.to_bus));

  // R7
  quiet_in_addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ale |-> !steer.to_cpu && !steer.to_bus);

  // R8
  ack_reads_vector_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (inta && !ale && !ACK_NEEDS_DEN) |-> steer.to_cpu && !steer.to_bus && steer.dir_cpu);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_ok |-> !steer.to_cpu && !steer.to_bus);
endmodule

// File: rtl/cpu_bus_demux.sv
module cpu_bus_demux
  import bdmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LO_W-1:0]   cpu_ad_i,
  input  logic [MID_W-1:0]  cpu_amid_i,
  input  logic [HI_W-1:0]   cpu_ahi_i,
  input  logic              ale_i,
  input  logic              rd_n_i,
  input  logic              den_i,
  input  logic              inta_i,
  input  logic [LO_W-1:0]   sys_d_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cpu_oe_o,
  output logic              bus_oe_o,
  output logic              dir_to_cpu_o,
  output logic [LO_W-1:0]   cpu_d_o,
  output logic [LO_W-1:0]   sys_d_o
);
  logic              rst_ok;
  logic [LO_W-1:0]   lo_q;
  logic [MLAT_W-1:0] mid_q;
  logic [HI_W-1:0]   hi_q;
  steer_t            steer;

  bdmx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  bdmx_addr_latch #(.LO_W(LO_W), .MLAT_W(MLAT_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst_n(rst_ok), .ale(ale_i),
    .lo_pin(cpu_ad_i), .mid_pin(cpu_amid_i[MLAT_W-1:0]), .hi_pin(cpu_ahi_i),
    .lo_q(lo_q), .mid_q(mid_q), .hi_q(hi_q)
  );

  bdmx_data_steer #(.DW(LO_W), .ACK_NEEDS_DEN(1'b0)) u_steer (
    .clk(clk), .rst_ok(rst_ok), .ale(ale_i), .den(den_i), .rd_n(rd_n_i),
    .inta(inta_i), .cpu_ad(cpu_ad_i), .sys_d(sys_d_i),
    .steer(steer), .cpu_d(cpu_d_o), .bus_d(sys_d_o)
  );

  assign addr_o       = {hi_q, cpu_amid_i[MID_W-1:MLAT_W], mid_q, lo_q};
  assign cpu_oe_o     = steer.to_cpu;
  assign bus_oe_o     = steer.to_bus;
  assign dir_to_cpu_o = steer.dir_cpu;

  // R3
  upper_mid_passes_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    addr_o[LO_W+MID_W-1:LO_W+MLAT_W] == cpu_amid_i[MID_W-1:MLAT_W]);

  // R4
  read_path_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ale_i && den_i && !inta_i && !rd_n_i) |-> cpu_oe_o && (cpu_d_o == sys_d_i));

  // R5
  write_path_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ale_i && den_i && !inta_i && rd_n_i) |-> bus_oe_o && (sys_d_o == cpu_ad_i));
endmodule

// File: tb/cpu_bus_demux_tb.sv
module cpu_bus_demux_tb;
  logic        clk;
  logic        rst_n;
  logic [7:0]  cpu_ad_i, cpu_amid_i, sys_d_i;
  logic [3:0]  cpu_ahi_i;
  logic        ale_i, rd_n_i, den_i, inta_i;
  logic [19:0] addr_o;
  logic        cpu_oe_o, bus_oe_o, dir_to_cpu_o;
  logic [7:0]  cpu_d_o, sys_d_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  cpu_bus_demux u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_ad_i(cpu_ad_i), .cpu_amid_i(cpu_amid_i),
    .cpu_ahi_i(cpu_ahi_i), .ale_i(ale_i), .rd_n_i(rd_n_i), .den_i(den_i),
    .inta_i(inta_i), .sys_d_i(sys_d_i), .addr_o(addr_o), .cpu_oe_o(cpu_oe_o),
    .bus_oe_o(bus_oe_o), .dir_to_cpu_o(dir_to_cpu_o), .cpu_d_o(cpu_d_o),
    .sys_d_o(sys_d_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: {ale,den,rd_n,inta, ad[8], sysd[8], exp_cpu_oe, exp_bus_oe, exp_dir, pad}
  localparam logic [23:0] VEC [10] = '{
    {4'b0100, 8'h3A, 8'hC5, 4'b1010},
    {4'b0110, 8'h5C, 8'h81, 4'b0100},
    {4'b0000, 8'h11, 8'h22, 4'b0010},
    {4'b0010, 8'h33, 8'h44, 4'b0000},
    {4'b1100, 8'h66, 8'h77, 4'b0010},
    {4'b1110, 8'h99, 8'hAA, 4'b0000},
    {4'b1011, 8'hBB, 8'hCC, 4'b0010},
    {4'b0111, 8'hDE, 8'h7E, 4'b1010},
    {4'b0011, 8'h0F, 8'hF0, 4'b1010},
    {4'b0101, 8'h42, 8'h24, 4'b1010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic a, input logic d, input logic r, input logic i);
    if (a)       return "R7";
    else if (i)  return "R8";
    else if (!d) return "R6";
    else if (!r) return "R4";
    else         return "R5";
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_ad_i = 8'h00; cpu_amid_i = 8'h00; cpu_ahi_i = 4'h0;
    ale_i = 1'b1; rd_n_i = 1'b1; den_i = 1'b1; inta_i = 1'b0; sys_d_i = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 addr in reset", {12'h0, addr_o}, 32'h0);
    ale_i = 1'b0;
    #1;
    chk("R10 enables in reset", {30'h0, cpu_oe_o, bus_oe_o}, 32'h0);

    // release: first edge after rise still in reset, second edge leaves it
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 first edge after release", {31'h0, bus_oe_o}, 32'h0);
    @(posedge clk); #1;
    chk("R10 second edge after release", {31'h0, bus_oe_o}, 32'h1);

    // vector walk: R4..R9
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      {ale_i, den_i, rd_n_i, inta_i} = VEC[k][23:20];
      cpu_ad_i = VEC[k][19:12];
      sys_d_i  = VEC[k][11:4];
      #1;
      chk(req_of(VEC[k][23], VEC[k][22], VEC[k][21], VEC[k][20]),
          {29'h0, cpu_oe_o, bus_oe_o, dir_to_cpu_o}, {29'h0, VEC[k][3:1]});
      chk("R9 single driver", {31'h0, cpu_oe_o & bus_oe_o}, 32'h0);
      chk(req_of(VEC[k][23], VEC[k][22], VEC[k][21], VEC[k][20]),
          {16'h0, cpu_d_o, sys_d_o},
          {16'h0, (VEC[k][3] ? VEC[k][11:4] : 8'h00), (VEC[k][2] ? VEC[k][19:12] : 8'h00)});
    end

    // R1 capture
    @(negedge clk);
    den_i = 1'b0; inta_i = 1'b0; ale_i = 1'b1;
    cpu_ad_i = 8'hA5; cpu_amid_i = 8'h3C; cpu_ahi_i = 4'h9;
    @(posedge clk); #1;
    chk("R1 capture", {12'h0, addr_o}, {12'h0, 20'h93CA5});

    // R2 hold while pins switch to data/status
    @(negedge clk);
    ale_i = 1'b0; cpu_ad_i = 8'hFF; cpu_amid_i = 8'hE7; cpu_ahi_i = 4'h6; den_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 hold", {12'h0, addr_o}, {12'h0, 20'h9ECA5});

    // R3 pass-through moves in same cycle, latched nibble does not
    @(negedge clk);
    cpu_amid_i = 8'h51;
    #1;
    chk("R3 pass-through", {12'h0, addr_o}, {12'h0, 20'h95CA5});

    // R1 second capture with different pattern
    @(negedge clk);
    ale_i = 1'b1; den_i = 1'b0; cpu_ad_i = 8'h0E; cpu_amid_i = 8'h7B; cpu_ahi_i = 4'hF;
    @(posedge clk); #1;
    chk("R1 recapture", {12'h0, addr_o}, {12'h0, 20'hF7B0E});

    // R10 mid-run reset clears latch at once
    @(negedge clk);
    ale_i = 1'b0; den_i = 1'b1; rd_n_i = 1'b0; cpu_amid_i = 8'h00; rst_n = 1'b0;
    #1;
    chk("R10 async clear", {12'h0, addr_o}, 32'h0);
    chk("R10 enables cleared", {30'h0, cpu_oe_o, bus_oe_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R4 after reset", {30'h0, cpu_oe_o, bus_oe_o}, 32'h2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule